// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This unit compares two single-precision floating-point operands under a 3-bit predicate. It returns a result mask and an invalid-operation flag. A true comparison gives a mask of all ones and a false comparison gives all zeros, so a datapath can use the mask directly for bitwise selection. The operands are classified first: zero, quiet NaN or signaling NaN. An ordering stage then finds less-than, equality and the unordered case. A predicate stage picks the answer and decides whether the operation is invalid.

Only eight predicates exist. The upper predicate bit inverts the lower four relations. Greater-than forms are obtained outside the unit by swapping the operands. Results are registered. They appear together with a result-valid strobe on the clock edge that samples the input strobe.

Top module: `fcmp_pred_unit`

## Requirements
- R1: Operands use sign at bit 31, exponent at bits 30:23 and fraction at bits 22:0. For ordered operands, predicate 3'b000 is true when a equals b, 3'b001 is true when a is less than b, and 3'b010 is true when a is less than or equal to b. This holds for positive, negative and mixed-sign values.
- R2: Predicates 3'b100, 3'b101 and 3'b110 return the exact inverse of 3'b000, 3'b001 and 3'b010, including when either operand is a NaN.
- R3: Predicate 3'b011 is true exactly when at least one operand is a NaN (exponent all ones, nonzero fraction). Predicate 3'b111 is its inverse.
- R4: When either operand is a NaN, predicates 3'b000, 3'b001, 3'b010 and 3'b111 are false, and the other four are true.
- R5: A quiet NaN (fraction bit 22 set) raises invalid only under predicates 3'b001, 3'b010, 3'b101 and 3'b110. Ordered operands never raise invalid.
- R6: A signaling NaN (fraction bit 22 clear, fraction nonzero) raises invalid under every predicate.
- R7: Positive zero and negative zero compare equal, and neither is less than the other.
- R8: Denormal operands are compared by their value and are not flushed to zero.
- R9: The result mask is either 32'hFFFF_FFFF (true) or 32'h0000_0000 (false).
- R10: The mask and the invalid flag are updated on the rising edge that samples in_valid high. res_valid is high for exactly the cycle after each in_valid. With in_valid low, the mask and the flag keep their values.
- R11: While rst_n is low, res_valid, res_invalid and res_mask are all zero.
- R12: Infinities are ordered values. Positive infinity is above every finite value, negative infinity is below every finite value, and equal infinities compare equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and predicate are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| pred | input | 3 | Predicate code |
| res_mask | output | 32 | All ones when the predicate holds, else zero |
| res_invalid | output | 1 | Invalid-operation flag for the last comparison |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |

## Verification
The bench builds the unit with its default parameters: 8 exponent bits, 23 fraction bits and a 32-bit mask. This is the single-precision layout, so the stimulus can use real encodings. These include plus and minus zero, the smallest denormals, largest finite values, both infinities, and quiet and signaling NaNs. With these encodings every predicate can be reached with ordered operands, with one NaN and with two NaNs. The vector table also covers the sign-magnitude boundary cases, where negative numbers order in reverse of their raw bit patterns.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;

   // Predicate codes: bit 2 inverts the relation chosen by bits 1:0.
   typedef enum logic [2:0] {
      PR_EQ    = 3'd0,
      PR_LT    = 3'd1,
      PR_LE    = 3'd2,
      PR_UNORD = 3'd3,
      PR_NEQ   = 3'd4,
      PR_NLT   = 3'd5,
      PR_NLE   = 3'd6,
      PR_ORD   = 3'd7
   } fcmp_pred_e;

   typedef struct packed {
      logic sign;
      logic is_zero;
      logic is_nan;
      logic is_snan;
   } fcmp_class_t;

endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic [OP_W-1:0] opnd,
   output fcmp_class_t     cls,
   output logic [OP_W-2:0] mag
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;

   always_comb begin
      exp_f       = opnd[OP_W-2 -: EXP_W];
      frac_f      = opnd[FRAC_W-1:0];
      exp_ones    = &exp_f;
      mag         = opnd[OP_W-2:0];
      cls.sign    = opnd[OP_W-1];
      cls.is_zero = (mag == '0);
      cls.is_nan  = exp_ones && (frac_f != '0);
      // The top fraction bit separates quiet from signaling NaNs.
      cls.is_snan = exp_ones && (frac_f != '0) && !frac_f[FRAC_W-1];
   end

endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int MAG_W = 31
) (
   input  fcmp_class_t      cls_a,
   input  fcmp_class_t      cls_b,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output logic             a_lt_b,
   output logic             a_eq_b,
   output logic             unord
);

   logic both_zero;
   logic mag_lt;
   logic mag_gt;
   logic mag_eq;

   always_comb begin
      both_zero = cls_a.is_zero && cls_b.is_zero;
      mag_lt    = mag_a < mag_b;
      mag_gt    = mag_a > mag_b;
      mag_eq    = mag_a == mag_b;
      unord     = cls_a.is_nan || cls_b.is_nan;
      a_eq_b    = both_zero || ((cls_a.sign == cls_b.sign) && mag_eq);
      if (both_zero)
         a_lt_b = 1'b0;
      else if (cls_a.sign != cls_b.sign)
         a_lt_b = cls_a.sign;
      else if (!cls_a.sign)
         a_lt_b = mag_lt;
      else
         a_lt_b = mag_gt;
   end

endmodule

// File: rtl/fcmp_predicate.sv
`timescale 1ns/1ps
module fcmp_predicate
   import fcmp_pkg::*;
(
   input  logic [2:0] pred,
   input  logic       a_lt_b,
   input  logic       a_eq_b,
   input  logic       unord,
   input  logic       any_snan,
   output logic       hit,
   output logic       invalid
);

   logic base;
   logic relational;

   always_comb begin
      unique case (pred[1:0])
         2'b00:   base = !unord && a_eq_b;
         2'b01:   base = !unord && a_lt_b;
         2'b10:   base = !unord && (a_lt_b || a_eq_b);
         default: base = unord;
      endcase
      hit        = base ^ pred[2];
      relational = (pred[1:0] == 2'b01) || (pred[1:0] == 2'b10);
      invalid    = any_snan || (unord && relational);
   end

endmodule

// File: rtl/fcmp_pred_unit.sv
`timescale 1ns/1ps
module fcmp_pred_unit
   import fcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int MASK_W = 32,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [OP_W-1:0]   op_a,
   input  logic [OP_W-1:0]   op_b,
   input  logic [2:0]        pred,
   output logic [MASK_W-1:0] res_mask,
   output logic              res_invalid,
   output logic              res_valid
);

   localparam int MAG_W = OP_W - 1;

   generate
      if (EXP_W < 2 || FRAC_W < 2) begin : g_bad_format
         $error("fcmp_pred_unit: exponent and fraction need at least 2 bits");
      end
      if (MASK_W < 1) begin : g_bad_mask
         $error("fcmp_pred_unit: MASK_W must be positive");
      end
   endgenerate

   logic [OP_W-1:0]  opnd [2];
   fcmp_class_t      cls  [2];
   logic [MAG_W-1:0] mag  [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_cls
         fcmp_classify #(
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
         ) i_classify (
            .opnd(opnd[gi]),
            .cls (cls[gi]),
            .mag (mag[gi])
         );
      end
   endgenerate

   logic a_lt_b;
   logic a_eq_b;
   logic unord;
   logic hit;
   logic invalid;

   fcmp_order #(
      .MAG_W(MAG_W)
   ) i_order (
      .cls_a (cls[0]),
      .cls_b (cls[1]),
      .mag_a (mag[0]),
      .mag_b (mag[1]),
      .a_lt_b(a_lt_b),
      .a_eq_b(a_eq_b),
      .unord (unord)
   );

   fcmp_predicate i_predicate (
      .pred    (pred),
      .a_lt_b  (a_lt_b),
      .a_eq_b  (a_eq_b),
      .unord   (unord),
      .any_snan(cls[0].is_snan || cls[1].is_snan),
      .hit     (hit),
      .invalid (invalid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_mask    <= '0;
         res_invalid <= 1'b0;
         res_valid   <= 1'b0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) begin
            res_mask    <= {MASK_W{hit}};
            res_invalid <= invalid;
         end
      end
   end

endmodule

// File: rtl/fcmp_pred_chk.sv
`timescale 1ns/1ps
module fcmp_pred_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int MASK_W = 32,
   localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [OP_W-1:0]   op_a,
   input logic [OP_W-1:0]   op_b,
   input logic [2:0]        pred,
   input logic [MASK_W-1:0] res_mask,
   input logic              res_invalid,
   input logic              res_valid
);

   logic nan_a, nan_b, snan_a, snan_b, zero_a, zero_b, false_on_nan;

   always_comb begin
      nan_a  = (&op_a[OP_W-2 -: EXP_W]) && (op_a[FRAC_W-1:0] != '0);
      nan_b  = (&op_b[OP_W-2 -: EXP_W]) && (op_b[FRAC_W-1:0] != '0);
      snan_a = nan_a && !op_a[FRAC_W-1];
      snan_b = nan_b && !op_b[FRAC_W-1];
      zero_a = op_a[OP_W-2:0] == '0;
      zero_b = op_b[OP_W-2:0] == '0;
      false_on_nan = (pred == 3'd0) || (pred == 3'd1) || (pred == 3'd2) || (pred == 3'd7);
   end

   p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid);

   p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res_mask) && $stable(res_invalid)));

   p_mask_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ($countones(res_mask) == 0 || $countones(res_mask) == MASK_W));

   p_nan_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (nan_a || nan_b) && false_on_nan) |=> (res_mask == '0));

   p_snan_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (snan_a || snan_b)) |=> res_invalid);

   p_ordered_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !nan_a && !nan_b) |=> !res_invalid);

   p_zero_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_a && zero_b && pred == 3'd0) |=> (res_mask == '1));

   p_reset_clear_r11: assert property (@(posedge clk)
      $rose(rst_n) |-> (!res_valid && !res_invalid && res_mask == '0));

endmodule

bind fcmp_pred_unit fcmp_pred_chk #(
   .EXP_W (EXP_W),
   .FRAC_W(FRAC_W),
   .MASK_W(MASK_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .op_a       (op_a),
   .op_b       (op_b),
   .pred       (pred),
   .res_mask   (res_mask),
   .res_invalid(res_invalid),
   .res_valid  (res_valid)
);

// File: tb/test_fcmp_pred_unit.sv
`timescale 1ns/1ps
module test_fcmp_pred_unit;

   localparam logic [31:0] P1   = 32'h3F80_0000; // +1.0
   localparam logic [31:0] P2   = 32'h4000_0000; // +2.0
   localparam logic [31:0] N1   = 32'hBF80_0000; // -1.0
   localparam logic [31:0] N2   = 32'hC000_0000; // -2.0
   localparam logic [31:0] PZ   = 32'h0000_0000;
   localparam logic [31:0] NZ   = 32'h8000_0000;
   localparam logic [31:0] QN   = 32'h7FC0_0000;
   localparam logic [31:0] SN   = 32'h7F80_0001;
   localparam logic [31:0] PINF = 32'h7F80_0000;
   localparam logic [31:0] NINF = 32'hFF80_0000;
   localparam logic [31:0] MAXF = 32'h7F7F_FFFF;
   localparam logic [31:0] D1   = 32'h0000_0001;
   localparam logic [31:0] D2   = 32'h0000_0002;
   localparam logic [31:0] ND1  = 32'h8000_0001;

   // {a, b, pred, expected true, expected invalid, requirement number}
   localparam int NV = 40;
   localparam logic [72:0] VEC [NV] = '{
      {P1, P2, 3'd1, 1'b1, 1'b0, 4'd1},   // R1
      {P2, P1, 3'd1, 1'b0, 1'b0, 4'd1},   // R1
      {P1, P1, 3'd2, 1'b1, 1'b0, 4'd1},   // R1
      {P1, P1, 3'd0, 1'b1, 1'b0, 4'd1},   // R1
      {N2, N1, 3'd1, 1'b1, 1'b0, 4'd1},   // R1 negatives reverse bit order
      {N1, N2, 3'd1, 1'b0, 1'b0, 4'd1},   // R1
      {N1, P1, 3'd2, 1'b1, 1'b0, 4'd1},   // R1 mixed sign
      {P1, N1, 3'd0, 1'b0, 1'b0, 4'd1},   // R1
      {P1, P2, 3'd5, 1'b0, 1'b0, 4'd2},   // R2
      {P2, P1, 3'd6, 1'b1, 1'b0, 4'd2},   // R2
      {P1, P2, 3'd4, 1'b1, 1'b0, 4'd2},   // R2
      {P1, P1, 3'd4, 1'b0, 1'b0, 4'd2},   // R2
      {QN, P1, 3'd3, 1'b1, 1'b0, 4'd3},   // R3
      {P1, QN, 3'd7, 1'b0, 1'b0, 4'd3},   // R3
      {P1, P2, 3'd7, 1'b1, 1'b0, 4'd3},   // R3
      {P1, P2, 3'd3, 1'b0, 1'b0, 4'd3},   // R3
      {QN, P1, 3'd0, 1'b0, 1'b0, 4'd4},   // R4
      {QN, P1, 3'd4, 1'b1, 1'b0, 4'd4},   // R4
      {P1, QN, 3'd1, 1'b0, 1'b1, 4'd5},   // R5
      {QN, P1, 3'd5, 1'b1, 1'b1, 4'd5},   // R5
      {QN, P1, 3'd2, 1'b0, 1'b1, 4'd5},   // R5
      {P1, QN, 3'd6, 1'b1, 1'b1, 4'd5},   // R5
      {QN, QN, 3'd0, 1'b0, 1'b0, 4'd4},   // R4 two NaNs
      {SN, P1, 3'd0, 1'b0, 1'b1, 4'd6},   // R6
      {SN, P1, 3'd7, 1'b0, 1'b1, 4'd6},   // R6
      {P1, SN, 3'd3, 1'b1, 1'b1, 4'd6},   // R6
      {P1, SN, 3'd4, 1'b1, 1'b1, 4'd6},   // R6
      {QN, SN, 3'd1, 1'b0, 1'b1, 4'd6},   // R6
      {PZ, NZ, 3'd0, 1'b1, 1'b0, 4'd7},   // R7
      {PZ, NZ, 3'd1, 1'b0, 1'b0, 4'd7},   // R7
      {NZ, PZ, 3'd1, 1'b0, 1'b0, 4'd7},   // R7
      {NZ, PZ, 3'd2, 1'b1, 1'b0, 4'd7},   // R7
      {D1, D2, 3'd1, 1'b1, 1'b0, 4'd8},   // R8
      {D1, PZ, 3'd0, 1'b0, 1'b0, 4'd8},   // R8 no flush
      {ND1, PZ, 3'd1, 1'b1, 1'b0, 4'd8},  // R8
      {NZ, ND1, 3'd6, 1'b1, 1'b0, 4'd8},  // R8
      {NINF, N2, 3'd1, 1'b1, 1'b0, 4'd12}, // R12
      {PINF, MAXF, 3'd6, 1'b1, 1'b0, 4'd12}, // R12
      {PINF, PINF, 3'd0, 1'b1, 1'b0, 4'd12}, // R12
      {MAXF, PINF, 3'd1, 1'b1, 1'b0, 4'd12}  // R12
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0;
   logic [31:0] op_b = '0;
   logic [2:0]  pred = '0;
   logic [31:0] res_mask;
   logic        res_invalid;
   logic        res_valid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   fcmp_pred_unit i_fcmp_pred_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .op_a       (op_a),
      .op_b       (op_b),
      .pred       (pred),
      .res_mask   (res_mask),
      .res_invalid(res_invalid),
      .res_valid  (res_valid)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [2:0] p);
      @(negedge clk);
      op_a = a; op_b = b; pred = p; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs cleared during reset
      check("R11", "valid in reset", {31'b0, res_valid}, 32'h0);
      check("R11", "mask in reset", res_mask, 32'h0);
      check("R11", "invalid in reset", {31'b0, res_invalid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "idle valid", {31'b0, res_valid}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         logic [31:0] va, vb;
         logic [2:0]  vp;
         logic        vr, vi;
         logic [3:0]  vq;
         string       tag;
         {va, vb, vp, vr, vi, vq} = VEC[i];
         tag = $sformatf("R%0d", vq);
         apply(va, vb, vp);
         check(tag, $sformatf("vec %0d mask", i), res_mask, vr ? 32'hFFFF_FFFF : 32'h0);
         check(tag, $sformatf("vec %0d invalid", i), {31'b0, res_invalid}, {31'b0, vi});
         check("R10", $sformatf("vec %0d valid", i), {31'b0, res_valid}, 32'h1);
         check("R9", $sformatf("vec %0d mask form", i),
               {31'b0, (res_mask == 32'h0 || res_mask == 32'hFFFF_FFFF)}, 32'h1);
      end

      // R10: hold with no strobe; last vector gave true, no invalid
      @(negedge clk);
      op_a = QN; op_b = SN; pred = 3'd3;
      check("R10", "valid drops", {31'b0, res_valid}, 32'h0);
      @(negedge clk);
      check("R10", "mask held", res_mask, 32'hFFFF_FFFF);
      check("R10", "invalid held", {31'b0, res_invalid}, 32'h0);

      // R6 then R11: a result with invalid set is cleared by reset
      apply(SN, SN, 3'd4);
      check("R6", "snan pair invalid", {31'b0, res_invalid}, 32'h1);
      check("R2", "snan pair neq", res_mask, 32'hFFFF_FFFF);
      #2 rst_n = 1'b0;
      #1;
      check("R11", "mask after reset", res_mask, 32'h0);
      check("R11", "invalid after reset", {31'b0, res_invalid}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      // R2: back-to-back strobes, inverse pair on a NaN
      @(negedge clk);
      op_a = P1; op_b = QN; pred = 3'd1; in_valid = 1'b1;
      @(negedge clk);
      check("R2", "lt on nan", res_mask, 32'h0);
      pred = 3'd5;
      @(negedge clk);
      in_valid = 1'b0;
      check("R2", "nlt on nan", res_mask, 32'hFFFF_FFFF);
      check("R10", "back-to-back valid", {31'b0, res_valid}, 32'h1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule